// File: doc/BRIEF.md
# Edge-Timed Temporal Operator Set

This block holds a small set of clocked operators that compute on time rather than on binary words. Every operand is a single wire that starts low after reset and rises once. The cycle in which it rises is the value it carries: an earlier edge is a smaller number and a later edge a larger one. A wire that never rises stands for infinity.

Four operators are provided, side by side, under one wrapper:
- a latest-arrival operator (temporal maximum) built from an AND;
- an earliest-arrival operator (temporal minimum) built from an OR;
- a constant adder that shifts an edge later by a fixed number of cycles through a shift register;
- a suppression operator in which an early edge on a blocking input stops the data edge from ever appearing.

All four outputs latch once they rise. A synchronous reset between evaluations returns every register to its idle state so that the next evaluation can begin.

Top module: `race_ops`

## Requirements
- R1: `max_out` first rises in the cycle in which the last of the `max_in` bits has risen. If any bit never rises, `max_out` never rises.
- R2: `min_out` first rises in the cycle in which the first of the `min_in` bits rises. The output is combinational, so it rises in that same cycle.
- R3: If `dly_in` first rises in cycle x, `dly_out` first rises in cycle x + DELAY_K. For example, x = 2 and DELAY_K = 3 give cycle 5. If `dly_in` never rises, `dly_out` stays low.
- R4: If `inh_i` rises in a cycle strictly earlier than `inh_j`, `inh_out` never rises until reset. This holds even if `inh_i` later falls back to 0.
- R5: If `inh_j` rises in the same cycle as `inh_i` or earlier, `inh_out` rises in the cycle in which `inh_j` rises.
- R6: If `inh_i` never rises, `inh_out` follows the rise of `inh_j`. If `inh_j` never rises, `inh_out` stays low.
- R7: Once any output has risen, it stays high until reset, even if the inputs that caused it drop back to 0.
- R8: While `rst` is high at a clock edge, the delay line and the suppression state are cleared. With all inputs at 0, every output is then 0, and a previously blocked suppression operator passes its data edge again in the next evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; edges are sampled at its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| max_in | input | N_IN | Edge-coded operands of the latest-arrival operator |
| min_in | input | N_IN | Edge-coded operands of the earliest-arrival operator |
| dly_in | input | 1 | Edge-coded operand of the constant adder |
| inh_i | input | 1 | Blocking edge of the suppression operator |
| inh_j | input | 1 | Data edge of the suppression operator |
| max_out | output | 1 | Edge-coded latest arrival |
| min_out | output | 1 | Edge-coded earliest arrival |
| dly_out | output | 1 | Edge-coded `dly_in` + DELAY_K |
| inh_out | output | 1 | Data edge, or no edge if it was blocked |

## Verification
The hardest case to reach is the blocked suppression operator once the blocking wire has dropped again. A blocked state that does not hold looks correct whenever `inh_i` stays high. The bench therefore pulses `inh_i` for a single cycle before raising `inh_j`, and checks that the output stays low several cycles later. A second evaluation after reset then shows that the blocked state has been cleared. A table of edge times covers the tie, strictly-earlier and never-rising orderings for each operator. Directed glitch sequences drop every input after it has risen, to show that the outputs latch.

// File: rtl/race_ops.sv
`timescale 1ns/1ps
module race_ops #(
  parameter int N_IN    = 3,
  parameter int DELAY_K = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] max_in,
  input  logic [N_IN-1:0] min_in,
  input  logic            dly_in,
  input  logic            inh_i,
  input  logic            inh_j,
  output logic            max_out,
  output logic            min_out,
  output logic            dly_out,
  output logic            inh_out
);

  logic max_hold, min_hold, inh_pass, inh_blk;

  assign max_out = (&max_in) | max_hold;
  assign min_out = (|min_in) | min_hold;
  assign inh_out = inh_pass | (inh_j & ~inh_blk);

  always_ff @(posedge clk) begin
    if (rst) begin
      max_hold <= 1'b0;
      min_hold <= 1'b0;
      inh_pass <= 1'b0;
      inh_blk  <= 1'b0;
    end else begin
      max_hold <= max_out;
      min_hold <= min_out;
      inh_pass <= inh_out;
      inh_blk  <= inh_blk | (inh_i & ~inh_out);
    end
  end

  generate
    if (DELAY_K == 0) begin : g_wire
      logic hold;
      assign dly_out = dly_in | hold;
      always_ff @(posedge clk) begin
        if (rst) hold <= 1'b0;
        else     hold <= dly_out;
      end
    end else begin : g_line
      logic [DELAY_K-1:0] line;
      assign dly_out = line[DELAY_K-1];
      always_ff @(posedge clk) begin
        if (rst) begin
          line <= '0;
        end else begin
          line[0] <= line[0] | dly_in;
          for (int s = 1; s < DELAY_K; s++) line[s] <= line[s-1];
        end
      end

      p_dly_cleared_r8: assert property (@(posedge clk) rst |=> !dly_out)
        else $error("delay line not cleared by reset");
      p_dly_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        dly_out |=> dly_out)
        else $error("delayed edge dropped");
      p_dly_cause_r3: assert property (@(posedge clk) disable iff (rst)
        dly_out |-> line[0])
        else $error("delayed edge without an input edge");
    end
  endgenerate

  p_max_all_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(max_out) |-> (&max_in))
    else $error("max rose before all inputs arrived");
  p_min_any_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(min_out) |-> (|min_in))
    else $error("min rose with no input");
  p_inh_block_r4: assert property (@(posedge clk) disable iff (rst)
    (inh_blk && !inh_pass) |-> !inh_out)
    else $error("blocked data edge leaked");
  p_inh_cleared_r8: assert property (@(posedge clk) rst |=> (!inh_blk && !inh_pass))
    else $error("suppression state not cleared by reset");
  p_out_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (max_out && min_out && inh_out) |=> (max_out && min_out && inh_out))
    else $error("latched output dropped");

endmodule

// File: tb/race_ops_tb.sv
`timescale 1ns/1ps
module race_ops_tb;
  localparam int N_IN = 3;
  localparam int K    = 3;
  localparam int NEV  = 255;
  localparam int NV   = 8;
  localparam int RUNC = 24;

  // columns: max/min edge times a0 a1 a2, delay input x, blocking i, data j
  localparam int VEC [NV][6] = '{
    '{2, 4, 3,   2,   3,   2},
    '{0, 0, 0,   0,   1,   1},
    '{5, 1, 7,   4,   2,   6},
    '{3, 3, 3,   9,   0,   0},
    '{1, NEV, 2, NEV, NEV, 4},
    '{6, 2, 9,   1,   4,   NEV},
    '{0, 12, 5,  0,   0,   1},
    '{8, 8, 1,   5,   7,   7}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_IN-1:0] max_in = '0, min_in = '0;
  logic dly_in = 1'b0, inh_i = 1'b0, inh_j = 1'b0;
  logic max_out, min_out, dly_out, inh_out;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  race_ops #(.N_IN(N_IN), .DELAY_K(K)) u_dut (
    .clk(clk), .rst(rst), .max_in(max_in), .min_in(min_in), .dly_in(dly_in),
    .inh_i(inh_i), .inh_j(inh_j), .max_out(max_out), .min_out(min_out),
    .dly_out(dly_out), .inh_out(inh_out));

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; max_in = '0; min_in = '0; dly_in = 1'b0; inh_i = 1'b0; inh_j = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_vec(input int a0, input int a1, input int a2,
                         input int x, input int ti, input int tj);
    int f_max, f_min, f_dly, f_inh, e_max, e_min, e_dly, e_inh;
    f_max = NEV; f_min = NEV; f_dly = NEV; f_inh = NEV;
    do_reset();
    for (int c = 0; c <= RUNC; c++) begin
      max_in = {c >= a2, c >= a1, c >= a0};
      min_in = {c >= a2, c >= a1, c >= a0};
      dly_in = (c >= x);
      inh_i  = (c >= ti);
      inh_j  = (c >= tj);
      #1;
      if (max_out && f_max == NEV) f_max = c;
      if (min_out && f_min == NEV) f_min = c;
      if (dly_out && f_dly == NEV) f_dly = c;
      if (inh_out && f_inh == NEV) f_inh = c;
      @(negedge clk);
    end
    e_max = (a0 > a1) ? a0 : a1;  e_max = (a2 > e_max) ? a2 : e_max;
    e_min = (a0 < a1) ? a0 : a1;  e_min = (a2 < e_min) ? a2 : e_min;
    e_dly = (x == NEV) ? NEV : x + K;
    e_inh = (tj <= ti) ? tj : NEV;
    check("R1 max first rise", f_max, e_max);
    check("R2 min first rise", f_min, e_min);
    check("R3 delay first rise", f_dly, e_dly);
    if (e_inh == NEV && tj != NEV) check("R4 blocked data edge", f_inh, e_inh);
    else if (ti == NEV || tj == NEV) check("R6 one-sided inhibit", f_inh, e_inh);
    else check("R5 passed data edge", f_inh, e_inh);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R8: reset state with all inputs low
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R8 reset max_out", max_out, 0);
    check("R8 reset min_out", min_out, 0);
    check("R8 reset dly_out", dly_out, 0);
    check("R8 reset inh_out", inh_out, 0);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);

    // R7: every input rises in cycle 1 and drops in cycle 3
    do_reset();
    for (int c = 0; c <= 8; c++) begin
      if (c == 1) begin max_in = '1; min_in = '1; dly_in = 1; inh_j = 1; end
      if (c == 3) begin max_in = '0; min_in = '0; dly_in = 0; inh_j = 0; end
      #1;
      if (c == 8) begin
        check("R7 max_out held", max_out, 1);
        check("R7 min_out held", min_out, 1);
        check("R7 dly_out held", dly_out, 1);
        check("R7 inh_out held", inh_out, 1);
      end
      @(negedge clk);
    end

    // R8: reset in the middle of latched outputs clears them
    do_reset();
    #1;
    check("R8 cleared max_out", max_out, 0);
    check("R8 cleared dly_out", dly_out, 0);
    check("R8 cleared inh_out", inh_out, 0);

    // R4: one-cycle blocking pulse in cycle 2, data edge in cycle 5
    for (int c = 0; c <= 9; c++) begin
      inh_i = (c == 2);
      if (c >= 5) inh_j = 1;
      #1;
      if (c == 9) check("R4 blocked after pulse", inh_out, 0);
      @(negedge clk);
    end

    // R8: next evaluation after reset passes the data edge again
    do_reset();
    inh_j = 1; #1;
    check("R8 inhibit state cleared", inh_out, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule